// File: doc/BRIEF.md
# Buffer Diagnostic Command Controller

This block gives test software a way into a small sliced line buffer. Software writes a single 32-bit command word and the block carries out that command against an internal array. Each array entry holds four 32-bit data words and four parity bits, one parity bit per word. An entry is addressed by a slice, a buffer line and a register selector.

A command can do three kinds of work. It can write the four host-loaded data registers into an entry, or write a parity nibble into it, or both. It can read an entry back into the data registers, with the entry's parity returned in the command word. It can compare an entry against the data registers, against the parity nibble, or against both.

Reads and compares run for a fixed three cycles. During that time a busy flag is raised and further commands are dropped. Once a compare finishes, its outcome is held on a single match output.

Only slices 1 to 3 and lines 0 and 1 can be written. Every other position reads back as zero. For this reason the array stores only the writable positions.

Top module: `diag_cmd_ctrl`

## Requirements
- R1: After synchronous reset the command readback word, the four data registers, `busy` and `match` are all zero.
- R2: A read or compare command is accepted on the clock edge where `cmd_we` is high and `busy` is low. From that edge `busy` is 1, and its pending compare bits read back as 1 (parity compare at bit 23, data compare at bit 19). On the third edge after acceptance `busy`, bits 23 and 19 all return to 0, and the results become visible.
- R3: When data compare (bit 19) and read (bit 18) are set in the same command, the read is dropped. The data registers and the read-parity field (bits 31:28) keep their values, and only the compare runs.
- R4: The selector field is bits 7:5. Code 000 is the prefetch address, 010 the head address, 011 the stream start, 100 the entry count and 101 the slice data. Codes 001, 110 and 111 are no-ops: writes to them are dropped, reads of them return zero data and parity, and compares on them give `match` = 0.
- R5: A parity compare (bit 23) takes effect only with selector 101. In that case the entry's parity must equal the write-parity field (bits 27:24). With any other selector the bit is dropped, and if nothing else was requested `busy` stays 0.
- R6: The data-write strobe (bit 21) and the parity-write strobe (bit 20) change an entry only for slice 1 to 3 (bits 12:11) and line 0 or 1 (bits 10:8). Any other position stays zero and reads back as zero.
- R7: For selectors 000, 010 and 011, bits 3:0 of data word 0 are left unchanged by a data write and are excluded from a data compare.
- R8: A read (bit 18) loads the four words of the addressed entry into the data registers and places its parity in bits 31:28. Word i is bits 32*i+31:32*i of `dat_rdata`, and parity bit i belongs to word i.
- R9: The read bit and the two write strobes act only on the command write itself, and they always read back as 0.
- R10: While `busy` is 1, writes to the command word and to the data registers are ignored.
- R11: `match` holds its value until the next read or compare command is accepted, and it clears on that acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command word readback |
| dat_we | input | 1 | Data register write strobe |
| dat_idx | input | 2 | Data register index for a write |
| dat_wdata | input | 32 | Data register write value |
| dat_rdata | output | 128 | The four data registers, word 0 in the low bits |
| busy | output | 1 | Read or compare in progress |
| match | output | 1 | Outcome of the last compare |

## Verification
A wrong array entry cannot be seen by itself. It shows up only when software reads that entry back or compares against it. A lost write to the correct slot therefore appears as wrong data three cycles after a later read is accepted.

A fault in the latency counter changes the edge on which `busy` falls. It also changes the edge on which the pending compare bits clear. The bench samples exactly those edges, so this fault is caught within the command that triggers it.

Faults in the priority and validity gates show up differently. A wrong gate either leaves the data registers unexpectedly overwritten, or it turns a zero readback from a dropped position into stored data.

// File: rtl/diag_pkg.sv
package diag_pkg;

    localparam int CMD_W     = 32;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 4;
    localparam int LINE_BITS = NUM_WORDS * WORD_W;
    localparam int SLICE_W   = 2;
    localparam int LINE_W    = 3;
    localparam int NUM_SLOTS = 5;
    localparam int MASK_LSB  = 4;

    typedef enum logic [2:0] {
        SEL_PREFETCH = 3'b000,
        SEL_NOP_A    = 3'b001,
        SEL_HEAD     = 3'b010,
        SEL_START    = 3'b011,
        SEL_COUNT    = 3'b100,
        SEL_SLICE    = 3'b101,
        SEL_NOP_B    = 3'b110,
        SEL_NOP_C    = 3'b111
    } sel_e;

    typedef struct packed {
        logic [SLICE_W-1:0] slice;
        logic [LINE_W-1:0]  line;
        sel_e               sel;
    } addr_t;

    typedef struct packed {
        logic [NUM_WORDS-1:0] wpar;
        logic                 cmpp;
        logic                 ewd;
        logic                 ewp;
        logic                 cmpd;
        logic                 rd;
        addr_t                a;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] w);
        cmd_t c;
        c.wpar    = w[27:24];
        c.cmpp    = w[23];
        c.ewd     = w[21];
        c.ewp     = w[20];
        c.cmpd    = w[19];
        c.rd      = w[18];
        c.a.slice = w[12:11];
        c.a.line  = w[10:8];
        c.a.sel   = sel_e'(w[7:5]);
        return c;
    endfunction

    function automatic logic sel_valid(input sel_e s);
        return !(s == SEL_NOP_A || s == SEL_NOP_B || s == SEL_NOP_C);
    endfunction

    function automatic logic [2:0] sel_slot(input sel_e s);
        case (s)
            SEL_HEAD:  return 3'd1;
            SEL_START: return 3'd2;
            SEL_COUNT: return 3'd3;
            SEL_SLICE: return 3'd4;
            default:   return 3'd0;
        endcase
    endfunction

    // selections whose word-0 low nibble is left out of writes and compares
    function automatic logic [LINE_BITS-1:0] keep_mask(input sel_e s);
        logic [LINE_BITS-1:0] m;
        m = '0;
        if (s == SEL_PREFETCH || s == SEL_HEAD || s == SEL_START)
            m[MASK_LSB-1:0] = '1;
        return m;
    endfunction

endpackage

// File: rtl/diag_store.sv
module diag_store
    import diag_pkg::*;
#(
    parameter int NUM_SLICES  = 4,
    parameter int FIRST_SLICE = 1,
    parameter int VALID_LINES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  addr_t                addr,
    input  logic                 wr_data,
    input  logic                 wr_par,
    input  logic [LINE_BITS-1:0] wdata,
    input  logic [NUM_WORDS-1:0] wpar,
    output logic [LINE_BITS-1:0] rdata,
    output logic [NUM_WORDS-1:0] rpar
);
    localparam int VSLICES = NUM_SLICES - FIRST_SLICE;
    localparam int ENTRIES = VSLICES * VALID_LINES * NUM_SLOTS;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic [LINE_BITS-1:0] data_q [ENTRIES];
    logic [NUM_WORDS-1:0] par_q  [ENTRIES];
    logic                 hit;
    logic [IDX_W-1:0]     idx;
    logic [LINE_BITS-1:0] keep;
    int                   flat;

    always_comb begin
        hit  = sel_valid(addr.sel) && (int'(addr.slice) >= FIRST_SLICE)
             && (int'(addr.slice) < NUM_SLICES) && (int'(addr.line) < VALID_LINES);
        flat = ((int'(addr.slice) - FIRST_SLICE) * VALID_LINES + int'(addr.line)) * NUM_SLOTS
             + int'(sel_slot(addr.sel));
        idx  = hit ? IDX_W'(flat) : '0;
        keep = keep_mask(addr.sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                data_q[i] <= '0;
                par_q[i]  <= '0;
            end
        end else if (hit) begin
            if (wr_data) data_q[idx] <= (wdata & ~keep) | (data_q[idx] & keep);
            if (wr_par)  par_q[idx]  <= wpar;
        end
    end

    assign rdata = hit ? data_q[idx] : '0;
    assign rpar  = hit ? par_q[idx]  : '0;

endmodule

// File: rtl/diag_datregs.sv
module diag_datregs
    import diag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 busy,
    input  logic                 host_we,
    input  logic [1:0]           host_idx,
    input  logic [WORD_W-1:0]    host_wdata,
    input  logic                 load,
    input  logic [LINE_BITS-1:0] load_data,
    output logic [LINE_BITS-1:0] words
);
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[g*WORD_W +: WORD_W] <= '0;
            else if (load)
                words[g*WORD_W +: WORD_W] <= load_data[g*WORD_W +: WORD_W];
            else if (host_we && !busy && int'(host_idx) == g)
                words[g*WORD_W +: WORD_W] <= host_wdata;
        end
    end

    AST_HOST_BLOCKED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && host_we && !load) |=> $stable(words)); // R10

endmodule

// File: rtl/diag_seq.sv
module diag_seq
    import diag_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_we,
    input  logic [CMD_W-1:0]     cmd_wdata,
    input  logic [LINE_BITS-1:0] dat_q,
    input  logic [LINE_BITS-1:0] st_rdata,
    input  logic [NUM_WORDS-1:0] st_rpar,
    output addr_t                st_addr,
    output logic                 st_wr_data,
    output logic                 st_wr_par,
    output logic [NUM_WORDS-1:0] st_wpar,
    output logic                 load,
    output logic                 busy,
    output logic                 match,
    output logic [CMD_W-1:0]     cmd_rdata
);
    localparam int CNT_W = $clog2(LATENCY + 1);

    cmd_t                 in_c;
    addr_t                cur_q;
    logic [NUM_WORDS-1:0] wpar_q, rpar_q;
    logic                 busy_q, match_q, pend_rd_q, pend_cmpd_q, pend_cmpp_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 accept, cmpp_ok, start, done, cmp_ok;
    logic                 unused_bits;

    assign in_c        = decode_cmd(cmd_wdata);
    assign unused_bits = ^{cmd_wdata[31:28], cmd_wdata[22], cmd_wdata[17:13], cmd_wdata[4:0]};
    assign accept      = cmd_we && !busy_q;
    assign cmpp_ok     = in_c.cmpp && (in_c.a.sel == SEL_SLICE);
    assign start       = accept && (in_c.rd || in_c.cmpd || cmpp_ok);
    assign done        = busy_q && (cnt_q == '0);

    // writes use the incoming fields, completions the latched ones
    assign st_addr    = accept ? in_c.a : cur_q;
    assign st_wr_data = accept && in_c.ewd;
    assign st_wr_par  = accept && in_c.ewp;
    assign st_wpar    = in_c.wpar;

    assign cmp_ok = sel_valid(cur_q.sel)
        && (!pend_cmpd_q || (((st_rdata ^ dat_q) & ~keep_mask(cur_q.sel)) == '0))
        && (!pend_cmpp_q || (st_rpar == wpar_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q       <= '0;
            wpar_q      <= '0;
            rpar_q      <= '0;
            busy_q      <= 1'b0;
            cnt_q       <= '0;
            match_q     <= 1'b0;
            pend_rd_q   <= 1'b0;
            pend_cmpd_q <= 1'b0;
            pend_cmpp_q <= 1'b0;
        end else begin
            if (accept) begin
                cur_q       <= in_c.a;
                wpar_q      <= in_c.wpar;
                pend_cmpd_q <= in_c.cmpd;
                pend_cmpp_q <= cmpp_ok;
                pend_rd_q   <= in_c.rd && !in_c.cmpd;
            end
            if (start) begin
                busy_q  <= 1'b1;
                cnt_q   <= CNT_W'(LATENCY - 1);
                match_q <= 1'b0;
            end else if (done) begin
                busy_q      <= 1'b0;
                pend_rd_q   <= 1'b0;
                pend_cmpd_q <= 1'b0;
                pend_cmpp_q <= 1'b0;
                if (pend_cmpd_q || pend_cmpp_q) match_q <= cmp_ok;
                if (pend_rd_q) rpar_q <= st_rpar;
            end else if (busy_q) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign load      = done && pend_rd_q;
    assign busy      = busy_q;
    assign match     = match_q;
    assign cmd_rdata = {rpar_q, wpar_q, pend_cmpp_q, 1'b0, 2'b00, pend_cmpd_q, 1'b0,
                        5'b0, cur_q.slice, cur_q.line, cur_q.sel, 5'b0};

    AST_PENDING_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !(cmd_rdata[23] || cmd_rdata[19])); // R2
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0) |=> busy_q); // R2
    AST_CMPD_BLOCKS_RD: assert property (@(posedge clk) disable iff (rst)
        pend_cmpd_q |-> !pend_rd_q); // R3
    AST_CMPP_SLICE_ONLY: assert property (@(posedge clk) disable iff (rst)
        pend_cmpp_q |-> (cur_q.sel == SEL_SLICE)); // R5
    AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cmd_we) |=> $stable(cur_q)); // R10
    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !start) |=> $stable(match_q)); // R11

endmodule

// File: rtl/diag_cmd_ctrl.sv
module diag_cmd_ctrl
    import diag_pkg::*;
#(
    parameter int NUM_SLICES  = 4,
    parameter int FIRST_SLICE = 1,
    parameter int VALID_LINES = 2,
    parameter int LATENCY     = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_we,
    input  logic [CMD_W-1:0]     cmd_wdata,
    output logic [CMD_W-1:0]     cmd_rdata,
    input  logic                 dat_we,
    input  logic [1:0]           dat_idx,
    input  logic [WORD_W-1:0]    dat_wdata,
    output logic [LINE_BITS-1:0] dat_rdata,
    output logic                 busy,
    output logic                 match
);
    addr_t                st_addr;
    logic                 st_wr_data, st_wr_par, load;
    logic [NUM_WORDS-1:0] st_wpar, st_rpar;
    logic [LINE_BITS-1:0] st_rdata;

    diag_seq #(.LATENCY(LATENCY)) i_seq (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .dat_q(dat_rdata), .st_rdata(st_rdata), .st_rpar(st_rpar),
        .st_addr(st_addr), .st_wr_data(st_wr_data), .st_wr_par(st_wr_par),
        .st_wpar(st_wpar), .load(load), .busy(busy), .match(match),
        .cmd_rdata(cmd_rdata)
    );

    diag_store #(
        .NUM_SLICES(NUM_SLICES), .FIRST_SLICE(FIRST_SLICE), .VALID_LINES(VALID_LINES)
    ) i_store (
        .clk(clk), .rst(rst), .addr(st_addr), .wr_data(st_wr_data),
        .wr_par(st_wr_par), .wdata(dat_rdata), .wpar(st_wpar),
        .rdata(st_rdata), .rpar(st_rpar)
    );

    diag_datregs i_dat (
        .clk(clk), .rst(rst), .busy(busy), .host_we(dat_we), .host_idx(dat_idx),
        .host_wdata(dat_wdata), .load(load), .load_data(st_rdata), .words(dat_rdata)
    );

endmodule

// File: tb/test_diag_cmd_ctrl.sv
module test_diag_cmd_ctrl;

    logic         clk = 1'b0;
    logic         rst;
    logic         cmd_we;
    logic [31:0]  cmd_wdata;
    logic [31:0]  cmd_rdata;
    logic         dat_we;
    logic [1:0]   dat_idx;
    logic [31:0]  dat_wdata;
    logic [127:0] dat_rdata;
    logic         busy;
    logic         match;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    localparam logic [127:0] PAT_A = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
    localparam logic [127:0] PAT_B = {32'hCAFE_0004, 32'hCAFE_0003, 32'hCAFE_0002, 32'hCAFE_0001};

    always #2.5 clk = ~clk;

    diag_cmd_ctrl i_diag_cmd_ctrl (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .dat_we(dat_we), .dat_idx(dat_idx), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .busy(busy), .match(match)
    );

    task automatic check(input string req, input string what, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] wp, input logic cmpp, input logic ewd,
                                       input logic ewp, input logic cmpd, input logic rd,
                                       input logic [1:0] sl, input logic [2:0] ln,
                                       input logic [2:0] sel);
        return {4'h0, wp, cmpp, 1'b0, ewd, ewp, cmpd, rd, 5'b0, sl, ln, sel, 5'b0};
    endfunction

    task automatic issue(input logic [31:0] c);
        cmd_wdata = c;
        cmd_we    = 1'b1;
        @(negedge clk);
        cmd_we    = 1'b0;
    endtask

    task automatic finish_op();
        repeat (3) @(negedge clk);
    endtask

    task automatic set_dat(input logic [127:0] v);
        for (int i = 0; i < 4; i++) begin
            dat_we    = 1'b1;
            dat_idx   = 2'(i);
            dat_wdata = v[i*32 +: 32];
            @(negedge clk);
        end
        dat_we = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] sl, input logic [2:0] ln, input logic [2:0] sel);
        issue(mk(4'h0, 0, 0, 0, 0, 1, sl, ln, sel));
        finish_op();
    endtask

    task automatic t_reset();
        check("R1", "cmd_rdata", 128'(cmd_rdata), 128'h0);
        check("R1", "busy", 128'(busy), 128'h0);
        check("R1", "match", 128'(match), 128'h0);
        check("R1", "dat_rdata", dat_rdata, 128'h0);
    endtask

    task automatic t_write_read();
        set_dat(PAT_A);
        issue(mk(4'hA, 0, 1, 1, 0, 0, 2'd1, 3'd0, 3'b101));
        check("R9", "write strobes readback", 128'(cmd_rdata[21:20]), 128'h0);
        check("R9", "wpar field", 128'(cmd_rdata[27:24]), 128'hA);
        check("R2", "no busy on write", 128'(busy), 128'h0);
        set_dat(128'h0);
        issue(mk(4'h0, 0, 0, 0, 0, 1, 2'd1, 3'd0, 3'b101));
        check("R2", "busy after accept", 128'(busy), 128'h1);
        check("R9", "rd readback", 128'(cmd_rdata[18]), 128'h0);
        repeat (2) @(negedge clk);
        check("R2", "busy at second edge", 128'(busy), 128'h1);
        @(negedge clk);
        check("R2", "busy cleared at third edge", 128'(busy), 128'h0);
        check("R8", "read data", dat_rdata, PAT_A);
        check("R8", "read parity", 128'(cmd_rdata[31:28]), 128'hA);
        check("R8", "address fields", 128'(cmd_rdata[12:5]), 128'({2'd1, 3'd0, 3'b101}));
    endtask

    task automatic t_compare();
        issue(mk(4'h0, 0, 0, 0, 1, 0, 2'd1, 3'd0, 3'b101));
        check("R2", "cmpd pending", 128'(cmd_rdata[19]), 128'h1);
        finish_op();
        check("R2", "cmpd cleared", 128'(cmd_rdata[19]), 128'h0);
        check("R2", "data match", 128'(match), 128'h1);
        issue(mk(4'hA, 1, 0, 0, 1, 0, 2'd1, 3'd0, 3'b101));
        check("R2", "cmpp pending", 128'(cmd_rdata[23]), 128'h1);
        finish_op();
        check("R2", "cmpp cleared", 128'(cmd_rdata[23]), 128'h0);
        check("R5", "parity match", 128'(match), 128'h1);
        issue(mk(4'h5, 1, 0, 0, 1, 0, 2'd1, 3'd0, 3'b101));
        finish_op();
        check("R5", "parity mismatch", 128'(match), 128'h0);
    endtask

    task automatic t_cmpd_over_rd();
        set_dat({PAT_A[127:32], 32'hDEAD_0000});
        issue(mk(4'h0, 0, 0, 0, 1, 1, 2'd1, 3'd0, 3'b101));
        finish_op();
        check("R3", "compare ran", 128'(match), 128'h0);
        check("R3", "data regs kept", dat_rdata, {PAT_A[127:32], 32'hDEAD_0000});
        check("R3", "rpar kept", 128'(cmd_rdata[31:28]), 128'hA);
    endtask

    task automatic t_cmpp_wrong_sel();
        issue(mk(4'h0, 1, 0, 0, 0, 0, 2'd1, 3'd0, 3'b000));
        check("R5", "cmpp dropped busy", 128'(busy), 128'h0);
        check("R5", "cmpp dropped bit", 128'(cmd_rdata[23]), 128'h0);
    endtask

    task automatic t_mask();
        set_dat({32'h4, 32'h3, 32'h2, 32'h1234_5678});
        issue(mk(4'h0, 0, 1, 0, 0, 0, 2'd2, 3'd1, 3'b000));
        set_dat(128'h0);
        do_read(2'd2, 3'd1, 3'b000);
        check("R7", "nibble not written", dat_rdata, {32'h4, 32'h3, 32'h2, 32'h1234_5670});
        set_dat({32'h4, 32'h3, 32'h2, 32'h1234_567F});
        issue(mk(4'h0, 0, 0, 0, 1, 0, 2'd2, 3'd1, 3'b000));
        finish_op();
        check("R7", "nibble ignored in compare", 128'(match), 128'h1);
    endtask

    task automatic t_valid_range();
        set_dat(PAT_B);
        issue(mk(4'hF, 0, 1, 1, 0, 0, 2'd0, 3'd0, 3'b101));
        do_read(2'd0, 3'd0, 3'b101);
        check("R6", "slice 0 dropped", dat_rdata, 128'h0);
        check("R6", "slice 0 parity", 128'(cmd_rdata[31:28]), 128'h0);
        set_dat(PAT_B);
        issue(mk(4'hF, 0, 1, 1, 0, 0, 2'd3, 3'd2, 3'b101));
        do_read(2'd3, 3'd2, 3'b101);
        check("R6", "line 2 dropped", dat_rdata, 128'h0);
        set_dat(PAT_B);
        issue(mk(4'h6, 0, 1, 1, 0, 0, 2'd3, 3'd1, 3'b101));
        set_dat(128'h0);
        do_read(2'd3, 3'd1, 3'b101);
        check("R6", "slice 3 line 1 kept", dat_rdata, PAT_B);
        check("R6", "slice 3 line 1 parity", 128'(cmd_rdata[31:28]), 128'h6);
    endtask

    task automatic t_nop();
        set_dat(PAT_B);
        issue(mk(4'h3, 0, 1, 1, 0, 0, 2'd1, 3'd0, 3'b001));
        do_read(2'd1, 3'd0, 3'b001);
        check("R4", "nop read data", dat_rdata, 128'h0);
        check("R4", "nop read parity", 128'(cmd_rdata[31:28]), 128'h0);
        issue(mk(4'h0, 0, 0, 0, 1, 0, 2'd1, 3'd0, 3'b110));
        finish_op();
        check("R4", "nop compare", 128'(match), 128'h0);
        do_read(2'd1, 3'd0, 3'b101);
        check("R4", "slice data untouched", dat_rdata, PAT_A);
    endtask

    task automatic t_busy_ignore();
        issue(mk(4'h0, 0, 0, 0, 1, 0, 2'd1, 3'd0, 3'b101));
        cmd_wdata = mk(4'h0, 0, 1, 0, 0, 1, 2'd3, 3'd5, 3'b000);
        cmd_we    = 1'b1;
        dat_we    = 1'b1;
        dat_idx   = 2'd0;
        dat_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        cmd_we = 1'b0;
        dat_we = 1'b0;
        repeat (2) @(negedge clk);
        check("R10", "busy cmd ignored", 128'(cmd_rdata[12:8]), 128'({2'd1, 3'd0}));
        check("R10", "busy data ignored", dat_rdata, PAT_A);
        check("R10", "compare unaffected", 128'(match), 128'h1);
    endtask

    task automatic t_match_hold();
        issue(mk(4'h0, 0, 0, 1, 0, 0, 2'd3, 3'd1, 3'b101));
        @(negedge clk);
        check("R11", "match held over write", 128'(match), 128'h1);
        issue(mk(4'h0, 0, 0, 0, 0, 1, 2'd1, 3'd0, 3'b101));
        check("R11", "match cleared on accept", 128'(match), 128'h0);
        finish_op();
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        rst = 1'b1; cmd_we = 1'b0; cmd_wdata = '0;
        dat_we = 1'b0; dat_idx = '0; dat_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_read();
        t_compare();
        t_cmpd_over_rd();
        t_cmpp_wrong_sel();
        t_mask();
        t_valid_range();
        t_nop();
        t_busy_ignore();
        t_match_hold();
        finished = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end

endmodule